// File: doc/BRIEF.md
# Masked Content-Addressable Word Store

This block keeps a small set of data words that are located by their contents rather than by position. Each storage cell carries one extra occupancy flag above its data bits. A lookup presents a key and a bit mask. The key is compared against every cell at once, and only the bit positions whose mask bit is 1 take part. The result is a per-cell hit vector. From that vector the block derives a match count and three exclusive outcome flags: no hit, a single hit, or several hits. All of these are registered, so they appear together one clock after the request is taken.

A read uses the same lookup. It returns the data of the lowest-numbered cell that hits, or it is cancelled when nothing hits. A write first runs a free-cell scan over the same compare path. That scan uses a fixed key and mask that look only at the occupancy flag. The word then goes into the lowest-numbered free cell, or the write is refused with a one-cycle full pulse when no cell is free. A clear releases the one cell named by the latest single-hit result.

Control is a two-state machine. `ST_IDLE` accepts requests. `ST_FREE_SCAN` spends one cycle on the free-cell search of a write. There are two transitions: the *write-accept* transition goes from `ST_IDLE` to `ST_FREE_SCAN`, and the *scan-finish* transition returns from `ST_FREE_SCAN` to `ST_IDLE` unconditionally. Lookups, reads and clears complete without leaving `ST_IDLE`.

Top module: `cam_store`

## Requirements
- R1: After reset every cell is free, `ready` is 1, `done`, `rvalid` and `full` are 0, `match_vec` and `hit_count` are 0, and `none_hit` is 1.
- R2: A request is taken when `op_valid` is 1 in a cycle where `ready` is 1. The code on `op_code` selects the operation: 0 = lookup, 1 = read, 2 = write, 3 = clear. For a lookup or read taken on edge t, `done` is 1 during the cycle after edge t. In that same cycle `match_vec` bit j is 1 exactly when cell j is occupied and, at every bit position where `mask` is 1, the cell's data bit equals `key`. Positions where `mask` is 0 are ignored.
- R3: Exactly one of `none_hit`, `one_hit` and `many_hit` is 1 at all times. The flag that is set corresponds to zero, one, or two or more set bits in `match_vec`.
- R4: `hit_count` always equals the number of set bits in `match_vec`.
- R5: A read with at least one hit pulses `rvalid` for one cycle together with `done`, and `rdata` shows the data of the lowest-numbered hitting cell. A read with no hit leaves `rvalid` at 0 and sets `rdata` to 0.
- R6: A write taken on edge t runs the free-cell scan in the next cycle. Its results appear with `done` after edge t+1. `match_vec` then marks the cells that were free before the write, `hit_count` gives how many there were, and `wdata` is stored into the lowest-numbered of them, which becomes occupied.
- R7: When a write finds no free cell, no cell changes. `full` is 1 for exactly the one cycle in which `done` is 1, and `none_hit` is also 1 in that cycle.
- R8: A clear takes effect only when `one_hit` is 1 at the time the clear is taken. In that case the cell marked in `match_vec` becomes free. Otherwise nothing changes. In both cases `done` pulses one cycle later and the result outputs are left as they were.
- R9: A free cell never hits in a lookup or read, whatever its old data bits hold and whatever the mask, including an all-zero mask.
- R10: `ready` is 0 during the free-scan cycle of a write, and a request presented in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 2 | 0 lookup, 1 read, 2 write, 3 clear |
| key | input | WIDTH | Lookup key |
| mask | input | WIDTH | 1 marks a bit position that is compared |
| wdata | input | WIDTH | Word to store on a write |
| ready | output | 1 | Block can take a request |
| done | output | 1 | One-cycle pulse when a request completes |
| match_vec | output | WORDS | Registered per-cell hit vector |
| none_hit | output | 1 | No cell hit |
| one_hit | output | 1 | Exactly one cell hit |
| many_hit | output | 1 | Two or more cells hit |
| hit_count | output | $clog2(WORDS+1) | Number of hits |
| rdata | output | WIDTH | Data returned by a read |
| rvalid | output | 1 | Read returned a word |
| full | output | 1 | Write refused because no cell is free |

## Verification
Several properties are checked on every cycle:
- The three outcome flags stay exclusive and agree with the count.
- The count agrees with the hit vector.
- `full` and `rvalid` only appear alongside `done`, with consistent flags.
- The free-scan state always lasts exactly one cycle.
- A successful scan raises the number of occupied cells by exactly one, and a refused scan leaves the occupancy flags untouched.

The bench scenarios cover what no per-cycle property can show:
- Which cell a write lands in.
- Which word a multi-hit read returns.
- Whether masked-off bit positions are really ignored.
- That a cleared cell stops hitting while its old data bits remain.
- That a clear after a multi-hit result changes nothing.
- That a stray request during the scan cycle is dropped.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        OP_SEARCH = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_CLEAR  = 2'd3
    } cam_op_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_FREE_SCAN = 1'b1
    } cam_state_e;

endpackage

// File: rtl/cam_match.sv
module cam_match #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8
) (
    input  logic [WORDS-1:0][WIDTH:0] cells,
    input  logic [WIDTH:0]            key_full,
    input  logic [WIDTH:0]            mask_full,
    input  logic                      occ_gate,
    output logic [WORDS-1:0]          hits
);

    // One comparator per cell; the occupancy gate hides free cells in ordinary lookups
    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        logic diff_any;
        assign diff_any = |((cells[g] ^ key_full) & mask_full);
        assign hits[g]  = !diff_any && (!occ_gate || cells[g][WIDTH]);
    end

endmodule

// File: rtl/cam_resolve.sv
module cam_resolve #(
    parameter int WORDS = 8,
    parameter int CNT_W = $clog2(WORDS + 1),
    parameter int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [WORDS-1:0] hits,
    output logic [CNT_W-1:0] count,
    output logic             none,
    output logic             one,
    output logic             many,
    output logic             found,
    output logic [IDX_W-1:0] lowest
);

    always_comb begin
        count = '0;
        for (int i = 0; i < WORDS; i++) begin
            count = count + CNT_W'(hits[i]);
        end
    end

    // Scan from the top so the smallest hitting index wins
    always_comb begin
        lowest = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (hits[i]) lowest = IDX_W'(i);
        end
    end

    assign found = |hits;
    assign none  = (count == '0);
    assign one   = (count == CNT_W'(1));
    assign many  = (count > CNT_W'(1));

endmodule

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WORDS + 1),
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] wdata,
    output logic             ready,
    output logic             done,
    output logic [WORDS-1:0] match_vec,
    output logic             none_hit,
    output logic             one_hit,
    output logic             many_hit,
    output logic [CNT_W-1:0] hit_count,
    output logic [WIDTH-1:0] rdata,
    output logic             rvalid,
    output logic             full
);

    cam_state_e state, state_nx;
    cam_op_e    op;
    logic [WORDS-1:0][WIDTH:0] cells;
    logic [WIDTH-1:0]          pend_data;
    logic                      accept;
    logic                      scanning;

    logic [WIDTH:0]   key_full;
    logic [WIDTH:0]   mask_full;
    logic [WORDS-1:0] hits;
    logic [CNT_W-1:0] cnt;
    logic             f_none, f_one, f_many, found;
    logic [IDX_W-1:0] lowest;
    logic [WORDS-1:0] occ_vec;

    assign op       = cam_op_e'(op_code);
    assign scanning = (state == ST_FREE_SCAN);
    assign accept   = op_valid && (state == ST_IDLE);
    assign ready    = (state == ST_IDLE);

    for (genvar g = 0; g < WORDS; g++) begin : g_occ
        assign occ_vec[g] = cells[g][WIDTH];
    end

    // Shared compare path: free scan looks only at the occupancy flag for 0
    assign key_full  = scanning ? {1'b0, {WIDTH{1'b1}}} : {1'b0, key};
    assign mask_full = scanning ? {1'b1, {WIDTH{1'b0}}} : {1'b0, mask};

    cam_match #(.WORDS(WORDS), .WIDTH(WIDTH)) u_match (
        .cells     (cells),
        .key_full  (key_full),
        .mask_full (mask_full),
        .occ_gate  (!scanning),
        .hits      (hits)
    );

    cam_resolve #(.WORDS(WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_resolve (
        .hits   (hits),
        .count  (cnt),
        .none   (f_none),
        .one    (f_one),
        .many   (f_many),
        .found  (found),
        .lowest (lowest)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (accept && op == OP_WRITE) state_nx = ST_FREE_SCAN;
            ST_FREE_SCAN: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_data <= '0;
        else if (accept && op == OP_WRITE) pend_data <= wdata;
    end

    // Storage array: store after a successful scan, release on a single-hit clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (scanning && found) begin
            cells[lowest] <= {1'b1, pend_data};
        end else if (accept && op == OP_CLEAR && one_hit) begin
            for (int i = 0; i < WORDS; i++) begin
                if (match_vec[i]) cells[i][WIDTH] <= 1'b0;
            end
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            match_vec <= '0;
            none_hit  <= 1'b1;
            one_hit   <= 1'b0;
            many_hit  <= 1'b0;
            hit_count <= '0;
            rdata     <= '0;
            rvalid    <= 1'b0;
            full      <= 1'b0;
        end else begin
            done   <= 1'b0;
            rvalid <= 1'b0;
            full   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        case (op)
                            OP_SEARCH, OP_READ: begin
                                match_vec <= hits;
                                none_hit  <= f_none;
                                one_hit   <= f_one;
                                many_hit  <= f_many;
                                hit_count <= cnt;
                                done      <= 1'b1;
                                if (op == OP_READ) begin
                                    rvalid <= found;
                                    rdata  <= found ? cells[lowest][WIDTH-1:0] : '0;
                                end
                            end
                            OP_CLEAR: done <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_FREE_SCAN: begin
                    match_vec <= hits;
                    none_hit  <= f_none;
                    one_hit   <= f_one;
                    many_hit  <= f_many;
                    hit_count <= cnt;
                    done      <= 1'b1;
                    full      <= !found;
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({none_hit, one_hit, many_hit}));

    assert_count_vs_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hit_count) == $countones(match_vec));

    assert_read_has_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (done && !none_hit));

    assert_full_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (done && none_hit));

    assert_full_keeps_cells_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && !found) |=> $stable(occ_vec));

    assert_store_adds_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && found) |=> ($countones(occ_vec) == $past($countones(occ_vec)) + 1));

    assert_scan_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |=> (ready && state == ST_IDLE));

endmodule

// File: tb/cam_store_tb.sv
module cam_store_tb;
    import cam_pkg::*;

    localparam int WORDS = 8;
    localparam int WIDTH = 8;
    localparam int CNT_W = $clog2(WORDS + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [1:0]       op_code = 2'd0;
    logic [WIDTH-1:0] key = '0, mask = '0, wdata = '0;
    logic             ready, done, none_hit, one_hit, many_hit, rvalid, full;
    logic [WORDS-1:0] match_vec;
    logic [CNT_W-1:0] hit_count;
    logic [WIDTH-1:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .key(key), .mask(mask), .wdata(wdata), .ready(ready), .done(done),
        .match_vec(match_vec), .none_hit(none_hit), .one_hit(one_hit),
        .many_hit(many_hit), .hit_count(hit_count), .rdata(rdata),
        .rvalid(rvalid), .full(full)
    );

    // Reference model
    logic [WIDTH-1:0] m_data [WORDS];
    logic             m_occ  [WORDS];
    logic [WORDS-1:0] m_vec;

    function automatic logic [WORDS-1:0] ref_hits(input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m);
        logic [WORDS-1:0] v;
        for (int j = 0; j < WORDS; j++)
            v[j] = m_occ[j] && (((m_data[j] ^ k) & m) == '0);
        return v;
    endfunction

    function automatic logic [WORDS-1:0] ref_free();
        logic [WORDS-1:0] v;
        for (int j = 0; j < WORDS; j++) v[j] = !m_occ[j];
        return v;
    endfunction

    function automatic int popc(input logic [WORDS-1:0] v);
        int n = 0;
        for (int j = 0; j < WORDS; j++) n += int'(v[j]);
        return n;
    endfunction

    function automatic int lowest_of(input logic [WORDS-1:0] v);
        for (int j = 0; j < WORDS; j++) if (v[j]) return j;
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_result(input string req, input logic [WORDS-1:0] v);
        int n = popc(v);
        chk(req, "match_vec", 32'(match_vec), 32'(v));
        chk("R3", "none_hit", 32'(none_hit), 32'(n == 0));
        chk("R3", "one_hit",  32'(one_hit),  32'(n == 1));
        chk("R3", "many_hit", 32'(many_hit), 32'(n > 1));
        chk("R4", "hit_count", 32'(hit_count), 32'(n));
    endtask

    task automatic run_op(input logic [1:0] op, input logic [WIDTH-1:0] k,
                          input logic [WIDTH-1:0] m, input logic [WIDTH-1:0] d);
        logic [WORDS-1:0] v;
        int lo;
        @(negedge clk);
        chk("R2", "ready before request", 32'(ready), 32'd1);
        op_valid = 1'b1; op_code = op; key = k; mask = m; wdata = d;
        @(negedge clk);
        op_valid = 1'b0;
        case (op)
            OP_SEARCH, OP_READ: begin
                v = ref_hits(k, m);
                chk("R2", "done", 32'(done), 32'd1);
                chk_result("R2", v);
                chk("R9", "free cell hit", 32'(|(v ^ match_vec)), 32'd0);
                if (op == OP_READ) begin
                    lo = lowest_of(v);
                    chk("R5", "rvalid", 32'(rvalid), 32'(lo >= 0));
                    chk("R5", "rdata", 32'(rdata), (lo >= 0) ? 32'(m_data[lo]) : 32'd0);
                end else begin
                    chk("R5", "rvalid on lookup", 32'(rvalid), 32'd0);
                end
                m_vec = v;
            end
            OP_CLEAR: begin
                chk("R8", "done", 32'(done), 32'd1);
                chk_result("R8", m_vec);
                if (popc(m_vec) == 1) m_occ[lowest_of(m_vec)] = 1'b0;
            end
            default: begin
                chk("R10", "ready in scan", 32'(ready), 32'd0);
                chk("R6", "done early", 32'(done), 32'd0);
                // stray clear during the scan cycle must be dropped
                op_valid = 1'b1; op_code = OP_CLEAR;
                @(negedge clk);
                op_valid = 1'b0;
                v = ref_free();
                lo = lowest_of(v);
                chk("R6", "done", 32'(done), 32'd1);
                chk_result("R6", v);
                chk("R7", "full", 32'(full), 32'(lo < 0));
                if (lo >= 0) begin
                    m_occ[lo] = 1'b1;
                    m_data[lo] = d;
                end
                m_vec = v;
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_set;
        logic [WIDTH-1:0] rm;
        seed_set = $urandom(32'h5EED);
        for (int j = 0; j < WORDS; j++) begin m_data[j] = '0; m_occ[j] = 1'b0; end
        m_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", 32'(ready), 32'd1);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "rvalid", 32'(rvalid), 32'd0);
        chk("R1", "full", 32'(full), 32'd0);
        chk_result("R1", '0);

        // R9: all-zero mask on an empty array finds nothing
        run_op(OP_SEARCH, 8'h00, 8'h00, 8'h00);
        // fill the array (R6)
        for (int i = 0; i < WORDS; i++) run_op(OP_WRITE, 8'h00, 8'h00, (i % 3 == 0) ? 8'h11 : 8'(8'h20 + i));
        // R7: write with no free cell
        run_op(OP_WRITE, 8'h00, 8'h00, 8'h77);
        // multi-hit lookup and read of lowest (R3, R5)
        run_op(OP_SEARCH, 8'h11, 8'hFF, 8'h00);
        run_op(OP_READ, 8'h11, 8'hFF, 8'h00);
        // R8: clear after multi-hit changes nothing
        run_op(OP_CLEAR, 8'h00, 8'h00, 8'h00);
        run_op(OP_SEARCH, 8'h11, 8'hFF, 8'h00);
        // masked compare: high nibble only (R2)
        run_op(OP_READ, 8'h2F, 8'hF0, 8'h00);
        // single hit then clear, stale data must not hit (R8, R9)
        run_op(OP_SEARCH, 8'h22, 8'hFF, 8'h00);
        run_op(OP_CLEAR, 8'h00, 8'h00, 8'h00);
        run_op(OP_READ, 8'h22, 8'hFF, 8'h00);
        run_op(OP_SEARCH, 8'h00, 8'h00, 8'h00);
        // write refills the freed slot (R6)
        run_op(OP_WRITE, 8'h00, 8'h00, 8'h5A);
        run_op(OP_READ, 8'h5A, 8'hFF, 8'h00);

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int sel = int'($urandom % 10);
            int msel = int'($urandom % 5);
            logic [1:0] op;
            case (msel)
                0: rm = 8'hFF;
                1: rm = 8'h0F;
                2: rm = 8'h03;
                3: rm = 8'h00;
                default: rm = 8'($urandom);
            endcase
            if (sel < 3)      op = OP_SEARCH;
            else if (sel < 5) op = OP_READ;
            else if (sel < 7) op = OP_WRITE;
            else              op = OP_CLEAR;
            run_op(op, 8'($urandom % 16), rm, 8'($urandom % 16));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule